// File: doc/BRIEF.md
# Partitioned lane shifter

This block is a purely combinational 16-bit logical shifter whose datapath is cut into independent lanes at run time. A 3-bit cut vector selects the lane boundaries on a 4-bit grain. The legal settings are one 16-bit lane, two 8-bit lanes, or four 4-bit lanes. Every lane is shifted on its own. Bits that leave a lane are discarded, and zeros enter from the lane edge the data moves away from.

Two shift amount sources are served at once. The per-lane source takes each lane's amount from the bottom bits of the same lane of a second 16-bit operand. The broadcast source applies one amount, taken from the low bits of a 16-bit scalar, to every lane. Both sources produce a left result and a right result, so the block drives four 16-bit outputs from one set of inputs. A surrounding SIMD datapath picks the output it needs.

Top module: `simd_lane_shifter`

## Requirements
- R1: Cut bit i, when set, places a lane boundary between data bits 4i+3 and 4i+4. Cut 3'b000 gives one 16-bit lane, 3'b010 gives two 8-bit lanes (bits 7:0 and 15:8), and 3'b111 gives four 4-bit lanes.
- R2: In broadcast mode every lane of width W is shifted by bcast_amt modulo W, which is the low log2(W) bits of bcast_amt. Amounts of W or more wrap, and the higher bits of bcast_amt have no effect.
- R3: In per-lane mode a lane of width W that starts at bit L is shifted by lane_amt[L+log2(W)-1 : L].
- R4: A left shift moves bits toward the top of the lane and drops bits that pass the lane's top edge. Zeros enter at the lane's lowest bit.
- R5: A right shift moves bits toward the bottom of the lane and drops bits that pass the lane's bottom edge. Zeros enter at the lane's top bit.
- R6: Each lane's result depends only on that lane's input bits. No shifted-out bit ever appears in a neighbouring lane.
- R7: A lane with a shift amount of zero passes its input bits through unchanged on both the left and the right outputs.
- R8: The four outputs (per-lane left, per-lane right, broadcast left, broadcast right) are valid together, with no clock delay after the inputs settle.
- R9: Bits of lane_amt inside a lane but above that lane's amount field have no effect on the per-lane results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 16 | Data to be shifted |
| lane_amt | input | 16 | Per-lane shift amounts, each in its lane's lowest bits |
| bcast_amt | input | 16 | Single amount applied to every lane |
| cut | input | 3 | Lane boundary enables on a 4-bit grain |
| lane_shl | output | 16 | Per-lane left shift result |
| lane_shr | output | 16 | Per-lane right shift result |
| bcast_shl | output | 16 | Broadcast left shift result |
| bcast_shr | output | 16 | Broadcast right shift result |

## Verification
All four results are due in the same cycle as the stimulus, because there is no register between any input and any output. The bench drives a new input set just after a rising edge and samples all four outputs at the following falling edge, half a period later, so the shift network has settled. Expected values come from a lane-by-lane model that extracts each lane, shifts it by the amount reduced modulo the lane width, masks it, and puts it back.

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter #(
  parameter int WIDTH = 16,
  parameter int GRAIN = 4
) (
  input  logic [WIDTH-1:0]         din,
  input  logic [WIDTH-1:0]         lane_amt,
  input  logic [WIDTH-1:0]         bcast_amt,
  input  logic [WIDTH/GRAIN-2:0]   cut,
  output logic [WIDTH-1:0]         lane_shl,
  output logic [WIDTH-1:0]         lane_shr,
  output logic [WIDTH-1:0]         bcast_shl,
  output logic [WIDTH-1:0]         bcast_shr
);
  localparam int NSEG = WIDTH / GRAIN;
  localparam int NST  = $clog2(WIDTH);
  localparam int IW   = NST + 1;

  typedef logic [NSEG-1:0][IW-1:0]  pos_t;
  typedef logic [NSEG-1:0][NST-1:0] amt_t;

  pos_t lo_bit, hi_bit;
  amt_t amt_lane, amt_bcast;

  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      int lo_s, hi_s, w, kmax;
      lo_s = 0;
      for (int t = 0; t < s; t++)
        if (cut[t]) lo_s = t + 1;
      hi_s = NSEG - 1;
      for (int t = NSEG - 2; t >= s; t--)
        if (cut[t]) hi_s = t;
      w = (hi_s - lo_s + 1) * GRAIN;
      kmax = 0;
      for (int k = 0; k <= NST; k++)
        if ((1 << k) <= w) kmax = k;
      lo_bit[s] = IW'(lo_s * GRAIN);
      hi_bit[s] = IW'(hi_s * GRAIN + GRAIN - 1);
      for (int k = 0; k < NST; k++) begin
        amt_lane[s][k]  = (k < kmax) ? lane_amt[lo_s * GRAIN + k] : 1'b0;
        amt_bcast[s][k] = (k < kmax) ? bcast_amt[k] : 1'b0;
      end
    end
  end

  function automatic logic [WIDTH-1:0] lane_shift(
    input logic [WIDTH-1:0] d,
    input amt_t             amt,
    input logic             left,
    input pos_t             lo,
    input pos_t             hi
  );
    logic [WIDTH-1:0] cur, nxt;
    cur = d;
    for (int k = 0; k < NST; k++) begin
      for (int j = 0; j < WIDTH; j++) begin
        int s, src;
        s = j / GRAIN;
        nxt[j] = cur[j];
        if (amt[s][k]) begin
          nxt[j] = 1'b0;
          if (left) begin
            src = j - (1 << k);
            if (src >= int'(lo[s])) nxt[j] = cur[src];
          end else begin
            src = j + (1 << k);
            if (src <= int'(hi[s])) nxt[j] = cur[src];
          end
        end
      end
      cur = nxt;
    end
    return cur;
  endfunction

  assign lane_shl  = lane_shift(din, amt_lane,  1'b1, lo_bit, hi_bit);
  assign lane_shr  = lane_shift(din, amt_lane,  1'b0, lo_bit, hi_bit);
  assign bcast_shl = lane_shift(din, amt_bcast, 1'b1, lo_bit, hi_bit);
  assign bcast_shr = lane_shift(din, amt_bcast, 1'b0, lo_bit, hi_bit);

  always_comb begin
    if (!$isunknown({din, lane_amt, bcast_amt, cut})) begin
      a_r7_zero_passthrough: assert (bcast_amt[NST-1:0] != '0 || cut != '0 ||
                                     (bcast_shl == din && bcast_shr == din))
        else $error("zero broadcast amount altered data");
      a_r4_no_bit_gain_left: assert ($countones(lane_shl) <= $countones(din) &&
                                     $countones(bcast_shl) <= $countones(din))
        else $error("left shift created set bits");
      a_r5_no_bit_gain_right: assert ($countones(lane_shr) <= $countones(din) &&
                                      $countones(bcast_shr) <= $countones(din))
        else $error("right shift created set bits");
      for (int s = 0; s < NSEG; s++) begin
        if (amt_bcast[s][0]) begin
          a_r4_bottom_fill: assert (bcast_shl[lo_bit[s]] == 1'b0)
            else $error("left shift did not zero-fill lane bottom");
          a_r5_top_fill: assert (bcast_shr[hi_bit[s]] == 1'b0)
            else $error("right shift did not zero-fill lane top");
        end
      end
    end
  end
endmodule

// File: tb/simd_lane_shifter_tb_top.sv
module simd_lane_shifter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] din, lane_amt, bcast_amt;
  logic [2:0]  cut;
  logic [15:0] lane_shl, lane_shr, bcast_shl, bcast_shr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  simd_lane_shifter dut_i (
    .din(din), .lane_amt(lane_amt), .bcast_amt(bcast_amt), .cut(cut),
    .lane_shl(lane_shl), .lane_shr(lane_shr),
    .bcast_shl(bcast_shl), .bcast_shr(bcast_shr)
  );

  function automatic logic [15:0] model(input logic [15:0] d, input bit per_lane,
                                        input logic [15:0] b, input logic [15:0] s,
                                        input int w, input bit left);
    logic [31:0] res, m, v, a, r;
    res = 0;
    m = (32'd1 << w) - 1;
    for (int l = 0; l < 16 / w; l++) begin
      int lo;
      lo = l * w;
      v = ({16'd0, d} >> lo) & m;
      a = per_lane ? (({16'd0, b} >> lo) & (w - 1)) : ({16'd0, s} & (w - 1));
      r = left ? ((v << a) & m) : (v >> a);
      res |= r << lo;
    end
    return res[15:0];
  endfunction

  function automatic logic [2:0] cut_for(input int w);
    return (w == 16) ? 3'b000 : (w == 8) ? 3'b010 : 3'b111;
  endfunction

  task automatic cmp(input string req, input string name,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, name, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [15:0] d, input logic [15:0] b,
                     input logic [15:0] s, input int w);
    @(posedge clk);
    din = d; lane_amt = b; bcast_amt = s; cut = cut_for(w);
    @(negedge clk);
    cmp(req, "lane_shl",  lane_shl,  model(d, 1, b, s, w, 1));
    cmp(req, "lane_shr",  lane_shr,  model(d, 1, b, s, w, 0));
    cmp(req, "bcast_shl", bcast_shl, model(d, 0, b, s, w, 1));
    cmp(req, "bcast_shr", bcast_shr, model(d, 0, b, s, w, 0));
  endtask

  task automatic t_idle;
    run("R8", 16'h0000, 16'h0000, 16'h0000, 16);
  endtask

  task automatic t_zero_amount;
    run("R7", 16'hA5C3, 16'h0000, 16'h0000, 16);
    run("R7", 16'h5A3C, 16'h0000, 16'h0000, 8);
    run("R7", 16'hF00F, 16'h0000, 16'h0000, 4);
  endtask

  task automatic t_single_lane;
    run("R4", 16'h8001, 16'h0001, 16'h0001, 16);
    run("R5", 16'h8001, 16'h000F, 16'h000F, 16);
    run("R2", 16'h1234, 16'h0007, 16'h0017, 16);
  endtask

  task automatic t_split_lanes;
    run("R1", 16'h8181, 16'h0301, 16'h0002, 8);
    run("R3", 16'hC3A5, 16'h0705, 16'h0003, 8);
    run("R1", 16'h9999, 16'h3210, 16'h0001, 4);
    run("R3", 16'hFFFF, 16'h1320, 16'h0002, 4);
  endtask

  task automatic t_wrap;
    run("R2", 16'h00F1, 16'h0000, 16'h0009, 8);
    run("R2", 16'h1248, 16'h0000, 16'hFFF5, 4);
    run("R2", 16'hBEEF, 16'h0000, 16'h0013, 16);
  endtask

  task automatic t_isolation;
    run("R6", 16'hFFFF, 16'h0404, 16'h0004, 8);
    run("R6", 16'hFFFF, 16'h3333, 16'h0003, 4);
    run("R6", 16'h8888, 16'h1111, 16'h0001, 4);
    run("R6", 16'h1111, 16'h2222, 16'h0002, 4);
  endtask

  task automatic t_upper_ignored;
    run("R9", 16'h6B2D, 16'hF8F9, 16'h0000, 8);
    run("R9", 16'h6B2D, 16'hCDEF, 16'h0000, 4);
    run("R9", 16'h6B2D, 16'hFFF2, 16'h0000, 16);
  endtask

  task automatic t_sweep;
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      logic [15:0] d, b, s;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; d = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; b = lf ^ 16'h5A5A;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; s = lf;
      run("R8", d, b, s, (i % 3 == 0) ? 16 : (i % 3 == 1) ? 8 : 4);
    end
  endtask

  initial begin
    din = '0; lane_amt = '0; bcast_amt = '0; cut = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle;
    t_zero_amount;
    t_single_lane;
    t_split_lanes;
    t_wrap;
    t_isolation;
    t_upper_ignored;
    t_sweep;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule